// File: doc/BRIEF.md
# Triggered chirp waveform player

This block replays one stored chirp, sample by sample, on a 16-bit converter data bus each time a trigger pulse arrives. An internal bank holds sixteen sample tables. Each table has its own programmable length, and its size is bounded by a depth parameter. A 4-bit select input chooses the table, and a delay input sets how many sample clocks pass between trigger acceptance and the first output word. Both the select and the delay are captured when a trigger is accepted. Changing them afterwards therefore affects only the following trigger and never the chirp already in flight.

The trigger is an asynchronous level. It passes through a two-stage synchroniser, and only its rising edge starts a playback. The busy output covers the whole span from trigger acceptance to the last emitted sample. Triggers that arrive during that span are dropped. Tables and lengths are loaded through a simple write port. The port is honoured only while the block is idle, so a playback always reads a table that cannot change under it.

Top module: `chirp_player`

## Requirements
- R1: While reset is held and after its release, `dac_data` is 0, `dac_valid` is 0 and `busy` is 0.
- R2: Suppose `trig_in` is first sampled high at clock edge k while the block is idle. Then `busy` becomes 1 after edge k+2, and never earlier. `busy` only rises on such an accepted edge.
- R3: With `delay_cfg` = D captured at acceptance, the first valid sample appears exactly D+1 cycles after `busy` rises. D = 0 gives the minimum latency of one cycle.
- R4: The samples of the selected table are emitted in address order from address 0, one per cycle. `dac_valid` stays high without gaps for the whole chirp.
- R5: A table whose length register holds the last index L emits exactly L+1 samples. L = DEPTH-1 uses the whole table.
- R6: `wave_sel` and `delay_cfg` are captured at trigger acceptance. Changing them while `busy` is high does not alter the chirp in progress.
- R7: A trigger rising edge seen while `busy` is high is ignored. A trigger held high produces exactly one playback and needs a new rising edge to start another.
- R8: `dac_data` is 0 (mid-scale, two's complement) in every cycle where `dac_valid` is 0.
- R9: `busy` stays high from acceptance through the cycle of the last valid sample and falls in the next cycle.
- R10: Sample writes (`wr_en`) and length writes (`len_we`) are discarded while `busy` is high. The next playback uses the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger level; rising edge starts a chirp |
| wave_sel | input | 4 | Table chosen for the next accepted trigger |
| delay_cfg | input | 12 | Extra delay in sample clocks for the next accepted trigger |
| wr_en | input | 1 | Sample write strobe (idle only) |
| wr_tbl | input | 4 | Table index for a sample write |
| wr_addr | input | 6 | Sample address inside the table |
| wr_data | input | 16 | Sample value to store |
| len_we | input | 1 | Length write strobe (idle only) |
| len_tbl | input | 4 | Table index for a length write |
| len_last | input | 6 | Index of the last sample to play for that table |
| dac_data | output | 16 | Output sample, 0 when not valid |
| dac_valid | output | 1 | High while a chirp sample is on `dac_data` |
| busy | output | 1 | High from trigger acceptance until the last sample has been emitted |

## Verification
The checker watches on every cycle that the output is zero whenever it is not valid. It also checks that valid samples occur only under busy, that the chirp runs without gaps, that busy starts only on a synchronised trigger edge and ends straight after a valid sample, and that the captured table index holds still while busy. The exact delay from trigger to first sample, the sample values and their order, the per-table lengths, the dropping of writes and of triggers during a playback, and the one-shot response to a held trigger all depend on table contents and on stimulus history. Only the bench scenarios can show these, by comparing the output against a scoreboard model of the bank.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_PLAY = 2'd2
    } phase_e;

endpackage

// File: rtl/chirp_trig_sync.sv
module chirp_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);
    // stage 0/1 synchronise, stage 2 holds the previous synchronised level
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], trig_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign trig_rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/chirp_wave_bank.sv
module chirp_wave_bank #(
    parameter int SEL_W    = 4,
    parameter int DEPTH    = 64,
    parameter int SAMPLE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_tbl,
    input  logic [$clog2(DEPTH)-1:0]     wr_addr,
    input  logic [SAMPLE_W-1:0]          wr_data,
    input  logic                         len_we,
    input  logic [SEL_W-1:0]             len_tbl,
    input  logic [$clog2(DEPTH)-1:0]     len_last,
    input  logic [SEL_W-1:0]             rd_tbl,
    input  logic [$clog2(DEPTH)-1:0]     rd_addr,
    output logic [SAMPLE_W-1:0]          rd_data,
    output logic [$clog2(DEPTH)-1:0]     rd_last
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int N_TBL  = 1 << SEL_W;
    localparam int WORDS  = N_TBL * DEPTH;

    logic [SAMPLE_W-1:0] mem [WORDS];
    logic [ADDR_W-1:0]   last_q [N_TBL];

    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_tbl, wr_addr}] <= wr_data;
    end

    for (genvar g = 0; g < N_TBL; g++) begin : g_len
        logic [ADDR_W-1:0] last_d;
        always_comb begin
            last_d = last_q[g];
            if (len_we && (len_tbl == SEL_W'(g))) last_d = len_last;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) last_q[g] <= ADDR_W'(DEPTH - 1);
            else        last_q[g] <= last_d;
        end
    end

    assign rd_data = mem[{rd_tbl, rd_addr}];
    assign rd_last = last_q[rd_tbl];
endmodule

// File: rtl/chirp_seq.sv
module chirp_seq
    import chirp_pkg::*;
#(
    parameter int SEL_W    = 4,
    parameter int ADDR_W   = 6,
    parameter int DLY_W    = 12,
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_rise,
    input  logic [SEL_W-1:0]    sel_in,
    input  logic [DLY_W-1:0]    dly_in,
    input  logic [SAMPLE_W-1:0] rd_data,
    input  logic [ADDR_W-1:0]   rd_last,
    output logic [SEL_W-1:0]    rd_tbl,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [SAMPLE_W-1:0] dout,
    output logic                dout_valid,
    output logic                busy
);
    typedef struct packed {
        phase_e              ph;
        logic [SEL_W-1:0]    tbl;
        logic [ADDR_W-1:0]   addr;
        logic [DLY_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] dout;
        logic                vld;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.dout = '0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (trig_rise && !st_q.vld) begin
                    st_d.tbl  = sel_in;
                    st_d.addr = '0;
                    if (dly_in == '0) begin
                        st_d.ph = PH_PLAY;
                    end else begin
                        st_d.ph  = PH_WAIT;
                        st_d.cnt = dly_in;
                    end
                end
            end
            PH_WAIT: begin
                if (st_q.cnt == DLY_W'(1)) st_d.ph  = PH_PLAY;
                else                       st_d.cnt = st_q.cnt - DLY_W'(1);
            end
            PH_PLAY: begin
                st_d.dout = rd_data;
                st_d.vld  = 1'b1;
                if (st_q.addr == rd_last) st_d.ph   = PH_IDLE;
                else                      st_d.addr = st_q.addr + ADDR_W'(1);
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_tbl     = st_q.tbl;
    assign rd_addr    = st_q.addr;
    assign dout       = st_q.dout;
    assign dout_valid = st_q.vld;
    assign busy       = (st_q.ph != PH_IDLE) | st_q.vld;
endmodule

// File: rtl/chirp_player.sv
module chirp_player #(
    parameter int SEL_W    = 4,
    parameter int DEPTH    = 64,
    parameter int SAMPLE_W = 16,
    parameter int DLY_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trig_in,
    input  logic [SEL_W-1:0]           wave_sel,
    input  logic [DLY_W-1:0]           delay_cfg,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_tbl,
    input  logic [$clog2(DEPTH)-1:0]   wr_addr,
    input  logic [SAMPLE_W-1:0]        wr_data,
    input  logic                       len_we,
    input  logic [SEL_W-1:0]           len_tbl,
    input  logic [$clog2(DEPTH)-1:0]   len_last,
    output logic [SAMPLE_W-1:0]        dac_data,
    output logic                       dac_valid,
    output logic                       busy
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic                trig_rise;
    logic [SEL_W-1:0]    act_tbl;
    logic [ADDR_W-1:0]   act_addr;
    logic [SAMPLE_W-1:0] bank_data;
    logic [ADDR_W-1:0]   bank_last;

    chirp_trig_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_rise (trig_rise)
    );

    chirp_wave_bank #(
        .SEL_W    (SEL_W),
        .DEPTH    (DEPTH),
        .SAMPLE_W (SAMPLE_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en & ~busy),
        .wr_tbl   (wr_tbl),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .len_we   (len_we & ~busy),
        .len_tbl  (len_tbl),
        .len_last (len_last),
        .rd_tbl   (act_tbl),
        .rd_addr  (act_addr),
        .rd_data  (bank_data),
        .rd_last  (bank_last)
    );

    chirp_seq #(
        .SEL_W    (SEL_W),
        .ADDR_W   (ADDR_W),
        .DLY_W    (DLY_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_rise  (trig_rise),
        .sel_in     (wave_sel),
        .dly_in     (delay_cfg),
        .rd_data    (bank_data),
        .rd_last    (bank_last),
        .rd_tbl     (act_tbl),
        .rd_addr    (act_addr),
        .dout       (dac_data),
        .dout_valid (dac_valid),
        .busy       (busy)
    );
endmodule

// File: rtl/chirp_player_chk.sv
module chirp_player_chk #(
    parameter int SEL_W    = 4,
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                trig_rise,
    input logic                busy,
    input logic [SAMPLE_W-1:0] dac_data,
    input logic                dac_valid,
    input logic [SEL_W-1:0]    act_tbl
);
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_valid |-> (dac_data == '0));

    // R9
    valid_under_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> busy);

    // R9
    end_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(dac_valid));

    // R2
    start_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig_rise));

    // R6
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(act_tbl));

    // R4
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_valid) |-> !busy);
endmodule

bind chirp_player chirp_player_chk #(
    .SEL_W    (SEL_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_rise (trig_rise),
    .busy      (busy),
    .dac_data  (dac_data),
    .dac_valid (dac_valid),
    .act_tbl   (act_tbl)
);

// File: tb/sim_chirp_player.sv
module sim_chirp_player;
    localparam int SEL_W = 4, DEPTH = 64, AW = 6, SW = 16, DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0;
    logic [SEL_W-1:0] wave_sel = '0;
    logic [DW-1:0] delay_cfg = '0;
    logic          wr_en = 1'b0, len_we = 1'b0;
    logic [SEL_W-1:0] wr_tbl = '0, len_tbl = '0;
    logic [AW-1:0] wr_addr = '0, len_last = '0;
    logic [SW-1:0] wr_data = '0;
    logic [SW-1:0] dac_data;
    logic          dac_valid, busy;

    always #10 clk = ~clk;

    chirp_player #(.SEL_W(SEL_W), .DEPTH(DEPTH), .SAMPLE_W(SW), .DLY_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .wave_sel(wave_sel),
        .delay_cfg(delay_cfg), .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_addr(wr_addr),
        .wr_data(wr_data), .len_we(len_we), .len_tbl(len_tbl), .len_last(len_last),
        .dac_data(dac_data), .dac_valid(dac_valid), .busy(busy)
    );

    logic [SW-1:0] bmem [16][DEPTH];
    int            blen [16];
    logic [SW-1:0] exp_q [$];
    int            dly_q [$];
    int n_chk = 0, n_err = 0, plays_exp = 0, plays_seen = 0, cyc = 0, rise_cyc = 0;
    int mon_d;
    logic [SW-1:0] mon_e;
    logic busy_prev = 1'b0, vld_prev = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy && !busy_prev) begin
                plays_seen++;
                rise_cyc = cyc;
            end
            if (dac_valid && !vld_prev) begin
                if (dly_q.size() == 0) check(1'b0, "R7 unexpected playback", 1, 0);
                else begin
                    mon_d = dly_q.pop_front();
                    check(cyc - rise_cyc == mon_d + 1, "R3 first sample latency", cyc - rise_cyc, mon_d + 1);
                end
            end
            if (dac_valid) begin
                if (exp_q.size() == 0) check(1'b0, "R5 extra sample", int'(dac_data), 0);
                else begin
                    mon_e = exp_q.pop_front();
                    check(dac_data == mon_e, "R4 sample value", int'(dac_data), int'(mon_e));
                end
            end else begin
                check(dac_data == '0, "R8 idle output", int'(dac_data), 0);
            end
            if (!busy && busy_prev)
                check(exp_q.size() == 0 && !dac_valid, "R5 R9 samples left at busy end", exp_q.size(), 0);
            busy_prev = busy;
            vld_prev  = dac_valid;
        end
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic wr_sample(input int t, input int a, input logic [SW-1:0] d, input bit upd);
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = SEL_W'(t); wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (upd) bmem[t][a] = d;
    endtask

    task automatic wr_len(input int t, input int l, input bit upd);
        @(negedge clk);
        len_we = 1'b1; len_tbl = SEL_W'(t); len_last = AW'(l);
        @(negedge clk);
        len_we = 1'b0;
        if (upd) blen[t] = l;
    endtask

    // driver: pushes the expected chirp, then raises the trigger (R2 timing)
    task automatic start_play(input int t, input int d, input bit hold);
        @(negedge clk);
        wave_sel = SEL_W'(t); delay_cfg = DW'(d);
        for (int a = 0; a <= blen[t]; a++) exp_q.push_back(bmem[t][a]);
        dly_q.push_back(d);
        plays_exp++;
        trig_in = 1'b1;
        @(negedge clk);
        check(!busy, "R2 busy too early (edge k)", busy, 0);
        @(negedge clk);
        check(!busy, "R2 busy too early (edge k+1)", busy, 0);
        @(negedge clk);
        check(busy, "R2 busy after edge k+2", busy, 1);
        if (!hold) trig_in = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(dac_data == '0 && !dac_valid && !busy, "R1 in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_data == '0 && !dac_valid && !busy, "R1 after reset", int'(busy), 0);

        for (int t = 0; t < 16; t++) begin
            for (int a = 0; a < DEPTH; a++) wr_sample(t, a, SW'(t * 4096 + a * 97 + 5), 1'b1);
            wr_len(t, (t == 15) ? DEPTH - 1 : t * 3 + 2, 1'b1);
        end

        // R3 minimal latency, R4 order, R5 lengths
        start_play(0, 0, 1'b0); wait_idle();
        start_play(3, 5, 1'b0); wait_idle();
        start_play(15, 0, 1'b0); wait_idle();   // R5 full depth
        start_play(7, 200, 1'b0); wait_idle();  // R3 long delay

        // R6 / R7 / R10: changes, trigger and writes while busy
        start_play(2, 4, 1'b0);
        @(negedge clk);
        wave_sel = 4'd9; delay_cfg = 12'd50;
        trig_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        trig_in = 1'b0;
        wr_sample(2, 0, 16'hDEAD, 1'b0);
        wr_len(2, 0, 1'b0);
        check(busy, "R10 writes issued while busy", busy, 1);
        wait_idle();
        repeat (4) @(negedge clk);
        check(!busy, "R7 trigger during busy ignored", busy, 0);
        start_play(2, 1, 1'b0); wait_idle();    // R10 old data and length kept

        // R7: trigger held high gives one playback
        start_play(5, 3, 1'b1);
        wait_idle();
        repeat (6) @(negedge clk);
        check(!busy, "R7 held trigger no retrigger", busy, 0);
        trig_in = 1'b0;
        repeat (2) @(negedge clk);
        start_play(9, 2, 1'b0); wait_idle();    // new edge rearms
        repeat (3) @(negedge clk);

        check(plays_seen == plays_exp, "R7 playback count", plays_seen, plays_exp);
        check(exp_q.size() == 0 && dly_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule